// File: doc/BRIEF.md
# Greedy Wildcard String Matcher

This block decides whether a stored text string matches a stored glob pattern. In the pattern, `?` stands for exactly one arbitrary byte and `*` stands for any run of bytes, including an empty run. Every other pattern byte must equal the text byte at the same position. The text and the pattern each live in their own internal byte buffer. Both buffers are filled through one byte-wide write stream, and a select bit on that stream chooses the target buffer.

Software loads the two strings, places their lengths on the length inputs and pulses `start`. The lengths are captured on that pulse. The engine then walks both strings one step per clock. It keeps only one recorded restart point: the text position at which the most recent `*` began absorbing bytes, and the pattern position just after that `*`. On a mismatch it returns to that point rather than filling a table of partial results. When the walk ends, `done` rises with the verdict on `match`. Both outputs hold until the next accepted start.

The write stream follows valid/ready rules. A byte transfers on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole time the engine is busy, so a writer has to hold its byte until the engine is idle. The buffers therefore never change during a match.

Top module: `glob_match_engine`

## Requirements
- R1: A `?` (byte 0x3F) in the pattern consumes exactly one text byte, whatever its value.
- R2: A `*` (byte 0x2A) in the pattern consumes any number of text bytes, zero included. Several `*` in a row act like one.
- R3: Any other pattern byte matches only a text byte of identical value.
- R4: If a mismatch occurs before any `*` has been passed, the result is no-match.
- R5: After a `*`, a mismatch restarts the comparison one text byte later than the previous restart, with the pattern resumed just after that `*`. The final verdict equals the glob-language definition for every pair of strings.
- R6: An empty text matches exactly those patterns made only of `*`, and the empty pattern is one of them.
- R7: A non-empty text never matches an empty pattern.
- R8: `done` and `match` stay constant from the moment `done` rises until the next accepted `start`.
- R9: A `start` pulse that arrives while `busy` is high has no effect on the running match or on its result.
- R10: `wr_ready` is low whenever `busy` is high. A byte is stored only on an edge with `wr_valid` and `wr_ready` both high, into the text buffer when `wr_sel`=0 and into the pattern buffer when `wr_sel`=1, at index `wr_addr`.
- R11: For text length T and pattern length P, `done` rises no more than (T+2)*(P+2)+4 clock cycles after `start` is accepted.
- R12: A length input above the buffer depth (64) is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Engine can accept a write byte |
| wr_sel | input | 1 | Target buffer: 0 text, 1 pattern |
| wr_addr | input | 6 | Byte index inside the selected buffer |
| wr_data | input | 8 | Byte value |
| txt_len | input | 7 | Text length, captured at start |
| pat_len | input | 7 | Pattern length, captured at start |
| start | input | 1 | Launch pulse, honoured only while idle |
| busy | output | 1 | Match in progress |
| done | output | 1 | Verdict available |
| match | output | 1 | Verdict: 1 means the text matches the pattern |

## Verification
The hardest situation to reach from the ports is a long chain of restarts. In that case a partial match after a `*` fails late, again and again, so the engine returns to its restart point many times before it settles. Inputs that also meet a full 64-byte text and 64-byte pattern drive the latency toward its bound. The stimulus builds such inputs deliberately: a run of one letter followed by a missing final letter, and patterns with several `*`-separated fragments that partially recur in the text. Each verdict is compared with a table-based reference computed in the bench, and the cycle count is compared with the bound from R11.

// File: rtl/glob_pkg.sv
package glob_pkg;
  localparam int unsigned BUF_DEPTH = 64;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_W    = $clog2(BUF_DEPTH);
  localparam int unsigned LEN_W     = ADDR_W + 1;

  localparam logic [BYTE_W-1:0] CH_STAR = 8'h2A;
  localparam logic [BYTE_W-1:0] CH_ONE  = 8'h3F;

  typedef enum logic [0:0] {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_t;
endpackage

// File: rtl/glob_buf.sv
module glob_buf #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/glob_core.sv
module glob_core
  import glob_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] txt_len,
  input  logic [LW-1:0] pat_len,
  input  logic [DW-1:0] txt_ch,
  input  logic [DW-1:0] pat_ch,
  output logic [AW-1:0] txt_idx,
  output logic [AW-1:0] pat_idx,
  output logic          busy,
  output logic          done,
  output logic          match
);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  eng_state_t    state;
  logic [LW-1:0] tlen_q, plen_q;
  logic [LW-1:0] ti, pi, rec_t, rec_p;
  logic          rec_v;

  logic [LW-1:0] ti_n, pi_n, rec_t_n, rec_p_n;
  logic          rec_v_n, fin, fin_res;
  logic          t_left, p_left, is_star, is_hit;

  assign txt_idx = ti[AW-1:0];
  assign pat_idx = pi[AW-1:0];
  assign busy    = (state == ENG_RUN);

  assign t_left  = (ti < tlen_q);
  assign p_left  = (pi < plen_q);
  assign is_star = p_left && (pat_ch == CH_STAR);
  assign is_hit  = p_left && !is_star && ((pat_ch == CH_ONE) || (pat_ch == txt_ch));

  // One greedy step per cycle.
  always_comb begin
    ti_n    = ti;
    pi_n    = pi;
    rec_t_n = rec_t;
    rec_p_n = rec_p;
    rec_v_n = rec_v;
    fin     = 1'b0;
    fin_res = 1'b0;
    if (t_left) begin
      if (is_star) begin
        pi_n    = pi + 1'b1;
        rec_t_n = ti;
        rec_p_n = pi + 1'b1;
        rec_v_n = 1'b1;
      end else if (is_hit) begin
        ti_n = ti + 1'b1;
        pi_n = pi + 1'b1;
      end else if (rec_v) begin
        rec_t_n = rec_t + 1'b1;
        ti_n    = rec_t + 1'b1;
        pi_n    = rec_p;
      end else begin
        fin = 1'b1;
      end
    end else begin
      if (!p_left) begin
        fin     = 1'b1;
        fin_res = 1'b1;
      end else if (is_star) begin
        pi_n = pi + 1'b1;
      end else begin
        fin = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ENG_IDLE;
      tlen_q <= '0;
      plen_q <= '0;
      ti     <= '0;
      pi     <= '0;
      rec_t  <= '0;
      rec_p  <= '0;
      rec_v  <= 1'b0;
      done   <= 1'b0;
      match  <= 1'b0;
    end else begin
      unique case (state)
        ENG_IDLE: begin
          if (start) begin
            tlen_q <= (txt_len > DEPTH_L) ? DEPTH_L : txt_len;
            plen_q <= (pat_len > DEPTH_L) ? DEPTH_L : pat_len;
            ti     <= '0;
            pi     <= '0;
            rec_t  <= '0;
            rec_p  <= '0;
            rec_v  <= 1'b0;
            done   <= 1'b0;
            match  <= 1'b0;
            state  <= ENG_RUN;
          end
        end
        ENG_RUN: begin
          ti    <= ti_n;
          pi    <= pi_n;
          rec_t <= rec_t_n;
          rec_p <= rec_p_n;
          rec_v <= rec_v_n;
          if (fin) begin
            done  <= 1'b1;
            match <= fin_res;
            state <= ENG_IDLE;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(match)));

  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(tlen_q) && $stable(plen_q)));

  a_r11_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ti <= tlen_q && pi <= plen_q && tlen_q <= DEPTH_L && plen_q <= DEPTH_L));

  a_r5_restart_behind: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rec_v) |-> (rec_t <= ti && rec_p <= pi));

  a_r2_star_arms_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && t_left && is_star) |=> rec_v);

  a_r4_no_restart_before_star: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rec_v) |-> (rec_t == '0 && rec_p == '0));

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/glob_match_engine.sv
module glob_match_engine
  import glob_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [LEN_W-1:0]  txt_len,
  input  logic [LEN_W-1:0]  pat_len,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              match
);
  logic              wr_fire;
  logic [1:0]        buf_we;
  logic [ADDR_W-1:0] rd_addr [2];
  logic [BYTE_W-1:0] rd_data [2];

  assign wr_ready = !busy;
  assign wr_fire  = wr_valid && wr_ready;

  // Buffer 0 holds the text, buffer 1 the pattern.
  for (genvar g = 0; g < 2; g++) begin : g_buf
    assign buf_we[g] = wr_fire && (wr_sel == 1'(g));
    glob_buf #(.DEPTH(BUF_DEPTH), .DW(BYTE_W)) u_buf (
      .clk   (clk),
      .we    (buf_we[g]),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr[g]),
      .rdata (rd_data[g])
    );
  end

  glob_core #(.DEPTH(BUF_DEPTH), .DW(BYTE_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .txt_len (txt_len),
    .pat_len (pat_len),
    .txt_ch  (rd_data[0]),
    .pat_ch  (rd_data[1]),
    .txt_idx (rd_addr[0]),
    .pat_idx (rd_addr[1]),
    .busy    (busy),
    .done    (done),
    .match   (match)
  );

  a_r10_no_write_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (buf_we == 2'b00));
endmodule

// File: tb/glob_match_engine_bench.sv
module glob_match_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic       wr_sel = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [6:0] txt_len = '0;
  logic [6:0] pat_len = '0;
  logic       start = 1'b0;
  logic       busy, done, match;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit monitor_on = 1'b0;

  always #2.5 clk = ~clk;

  glob_match_engine u_glob_match_engine (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .txt_len(txt_len), .pat_len(pat_len), .start(start),
    .busy(busy), .done(done), .match(match)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-clock comparison of the handshake rule: ready is the inverse of busy.
  always @(negedge clk) begin
    cyc++;
    if (monitor_on) begin
      check(wr_ready == !busy, "R10 ready/busy", wr_ready, !busy);
      if (done) check(!busy, "R8 done while busy", busy, 0);
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Table-based glob reference.
  function automatic bit ref_match(input string s, input string p);
    bit tab [0:64][0:64];
    int n = s.len();
    int m = p.len();
    tab[0][0] = 1'b1;
    for (int j = 1; j <= m; j++) tab[0][j] = tab[0][j-1] && (p[j-1] == "*");
    for (int i = 1; i <= n; i++) begin
      tab[i][0] = 1'b0;
      for (int j = 1; j <= m; j++) begin
        if (p[j-1] == "*") tab[i][j] = tab[i][j-1] || tab[i-1][j];
        else tab[i][j] = tab[i-1][j-1] && (p[j-1] == "?" || p[j-1] == s[i-1]);
      end
    end
    return tab[n][m];
  endfunction

  task automatic put_byte(input bit sel, input int addr, input byte val);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_addr = 6'(addr); wr_data = val;
    @(posedge clk);
    while (!wr_ready) @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic load(input string s, input string p);
    for (int i = 0; i < s.len(); i++) put_byte(1'b0, i, s[i]);
    for (int i = 0; i < p.len(); i++) put_byte(1'b1, i, p[i]);
  endtask

  task automatic launch(input int tl, input int pl);
    @(negedge clk);
    txt_len = 7'(tl); pat_len = 7'(pl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic await_done(output int lat);
    lat = 1;
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_case(input string s, input string p, input string req);
    int  lat;
    bit  exp;
    bit  held;
    load(s, p);
    exp = ref_match(s, p);
    launch(s.len(), p.len());
    check(busy && !done, {req, " busy after start"}, busy, 1);
    await_done(lat);
    check(done, {req, " done"}, done, 1);
    check(match == exp, {req, " verdict ", s, " / ", p}, match, exp);
    check(lat <= (s.len() + 2) * (p.len() + 2) + 4, "R11 latency", lat,
          (s.len() + 2) * (p.len() + 2) + 4);
    held = match;
    repeat (3) @(negedge clk);
    check(done && match == held, "R8 hold", match, held);
  endtask

  initial begin
    int lat;
    string la, lb;
    repeat (3) @(negedge clk);
    check(!busy && !done && !match, "R10 reset state", {busy, done, match}, 0);
    rst_n = 1'b1;
    monitor_on = 1'b1;

    run_case("abc", "abc", "R3");
    run_case("abc", "abd", "R3");
    run_case("zbc", "abc", "R4");
    run_case("abc", "a?c", "R1");
    run_case("ac", "a?c", "R1");
    run_case("abcd", "a*d", "R2");
    run_case("ad", "a**d", "R2");
    run_case("", "", "R6");
    run_case("", "***", "R6");
    run_case("", "*a*", "R6");
    run_case("abc", "", "R7");
    run_case("xaabcy", "*abc*", "R5");
    run_case("abcabd", "*ab?d", "R5");
    run_case("mississippi", "m??*ss*?i*pi", "R5");
    run_case("aaaa", "*a*b", "R5");
    run_case("abab", "*ab", "R5");
    run_case("ab", "*", "R2");

    // Long restart chain near full depth.
    la = ""; lb = "*";
    for (int i = 0; i < 63; i++) la = {la, "a"};
    la = {la, "c"};
    for (int i = 0; i < 30; i++) lb = {lb, "a"};
    lb = {lb, "b*"};
    run_case(la, lb, "R5");

    // R12: oversize lengths behave as 64.
    la = ""; lb = "";
    for (int i = 0; i < 64; i++) la = {la, "q"};
    for (int i = 0; i < 63; i++) lb = {lb, "?"};
    lb = {lb, "q"};
    load(la, lb);
    launch(100, 120);
    await_done(lat);
    check(done && match, "R12 clamp", match, 1);

    // R9: start during busy, with other lengths, must not disturb the match.
    load("abcdef", "abc?ef");
    launch(6, 6);
    @(negedge clk);
    txt_len = 7'd3; pat_len = 7'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    await_done(lat);
    check(done && match, "R9 start ignored", match, 1);

    // R10: writes offered while busy are refused; buffer is unchanged.
    load("abc", "abc");
    launch(3, 3);
    wr_valid = 1'b1; wr_sel = 1'b1; wr_addr = 6'd0; wr_data = "z";
    await_done(lat);
    wr_valid = 1'b0;
    launch(3, 3);
    await_done(lat);
    check(done && match, "R10 write refused while busy", match, 1);

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule